// File: doc/BRIEF.md
# Floppy Controller Host Port Decoder

This block sits between a home-computer expansion bus and a floppy disk controller core. It watches a 16-bit I/O address together with separate read and write strobes and turns them into a controller select, a register-select line and gated read and write enables for the controller's status and data registers. Decoding is deliberately sparse: only four address bits are examined, all of them compared against fixed levels, so a wide range of aliases reach the same target.

The same port map also holds a one-bit motor latch. A qualified write to the motor address copies bit 0 of the data bus into a flip-flop whose output is the single spindle-enable line shared by every attached drive. The latch is the only stored state in the block. The decode outputs are combinational and valid in the same cycle as the address and strobes. The motor output changes on the clock edge that samples the write.

Top module: `fdcio_decoder`

## Requirements
- R1: `ctl_sel` is high exactly when address bit 10 is 0, bit 7 is 0, bit 8 is 1, and either `ctl_rd` or `ctl_wr` is high in the same cycle.
- R2: Address bits 15..11, 9 and 6..1 have no effect on any output or on the motor latch.
- R3: `ctl_reg_sel` equals address bit 0 while `ctl_sel` is high (0 = status register, 1 = data register) and is 0 otherwise.
- R4: `ctl_rd` is high in the same cycle when `io_rd` is high, `io_wr` is low and the address has bit 10 = 0, bit 7 = 0, bit 8 = 1. This covers both the status address (bit 0 = 0) and the data address (bit 0 = 1).
- R5: `ctl_wr` is high only when `io_wr` is high, `io_rd` is low and the address has bit 10 = 0, bit 7 = 0, bit 8 = 1 and bit 0 = 1. A write to the status address (bit 0 = 0) raises neither `ctl_wr` nor `ctl_sel`.
- R6: A write cycle (`io_wr` high, `io_rd` low) to an address with bits 10, 8, 7 and 0 all 0 loads `io_d0` into the motor latch. `motor_on` shows the value after the next rising clock edge. 1 turns all motors on and 0 turns them off.
- R7: `motor_on` holds its value in every cycle without a motor write. This includes reads of the motor address and writes to the unassigned alias with bit 8 = 0 and bit 0 = 1.
- R8: When `io_rd` and `io_wr` are high together, `ctl_sel`, `ctl_rd` and `ctl_wr` stay low and the motor latch does not change.
- R9: A clock edge with `rst_n` low clears `motor_on` to 0, even when a motor write is presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 16 | Host I/O address |
| io_d0 | input | 1 | Bit 0 of the host data bus |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| ctl_sel | output | 1 | Controller chip select, active high |
| ctl_reg_sel | output | 1 | Register select: 0 status, 1 data |
| ctl_rd | output | 1 | Read enable to the controller |
| ctl_wr | output | 1 | Write enable to the controller |
| motor_on | output | 1 | Shared motor enable for all drives |

## Verification
The bench walks all sixteen level combinations of the four decoded address bits. Each combination is filled with many patterns of the ignored bits: all ones, all zeros, each single bit cleared, and alternating checkerboards. A fill that changed any result would expose a decoder that looks at bits it should not. Every address is tried with no strobe, a read, a write and both strobes together. These four cases separate read gating from write gating, show that the status address is read-only, and confirm that contention is suppressed. The data bit toggles from cycle to cycle, so the motor latch sees both loaded values and both held values, including writes to aliases that must leave it untouched. Reset is applied while a motor-on write is pending, to show that reset takes precedence.

// File: rtl/fdcio_pkg.sv
// Package: fdcio_pkg
// Shared types and default geometry for the floppy port decoder.
// Assumes a 16-bit I/O space with fixed positions for the decoded bits.
package fdcio_pkg;

    localparam int ADDR_W_DEF    = 16;
    localparam int BIT_EXP_DEF   = 10;  // low for any expansion access
    localparam int BIT_GRP_DEF   = 7;   // low selects the controller group
    localparam int BIT_FN_HI_DEF = 8;   // function select, high half
    localparam int BIT_FN_LO_DEF = 0;   // function select, low half

    // Decoded destination of the current bus address
    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_STATUS = 3'd1,
        TGT_DATA   = 3'd2,
        TGT_MOTOR  = 3'd3,
        TGT_SPARE  = 3'd4
    } fdcio_tgt_t;

endpackage

// File: rtl/fdcio_addr_match.sv
// Module: fdcio_addr_match
// Sparse partial address decoder. It examines only the four configured
// bit positions and maps them to a destination. It assumes the remaining
// address bits carry no meaning for this block.
module fdcio_addr_match
    import fdcio_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int BIT_EXP   = BIT_EXP_DEF,
    parameter int BIT_GRP   = BIT_GRP_DEF,
    parameter int BIT_FN_HI = BIT_FN_HI_DEF,
    parameter int BIT_FN_LO = BIT_FN_LO_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    output fdcio_tgt_t        tgt
);

    logic       grp_hit;
    logic [1:0] fn_code;

    // Purpose: qualify the access as belonging to the controller group
    always_comb begin
        grp_hit = !addr[BIT_EXP] && !addr[BIT_GRP];
        fn_code = {addr[BIT_FN_HI], addr[BIT_FN_LO]};
    end

    // Purpose: translate the function bits into a destination
    always_comb begin
        tgt = TGT_NONE;
        if (grp_hit) begin
            case (fn_code)
                2'b00:   tgt = TGT_MOTOR;
                2'b01:   tgt = TGT_SPARE;
                2'b10:   tgt = TGT_STATUS;
                default: tgt = TGT_DATA;
            endcase
        end
    end

endmodule

// File: rtl/fdcio_strobe_gate.sv
// Module: fdcio_strobe_gate
// Combines the decoded destination with the bus strobes. Drives the
// controller enables and the motor load enable. Assumes that read and
// write asserted together is a bus fault, which is suppressed.
module fdcio_strobe_gate
    import fdcio_pkg::*;
(
    input  fdcio_tgt_t tgt,
    input  logic       rd,
    input  logic       wr,
    output logic       ctl_sel,
    output logic       ctl_reg_sel,
    output logic       ctl_rd,
    output logic       ctl_wr,
    output logic       motor_we
);

    logic rd_only;
    logic wr_only;

    // Purpose: admit exactly one strobe at a time
    always_comb begin
        rd_only = rd && !wr;
        wr_only = wr && !rd;
    end

    // Purpose: produce the enables for the selected destination
    always_comb begin
        ctl_rd   = rd_only && (tgt == TGT_STATUS || tgt == TGT_DATA);
        ctl_wr   = wr_only && (tgt == TGT_DATA);
        motor_we = wr_only && (tgt == TGT_MOTOR);
        ctl_sel  = ctl_rd || ctl_wr;
        ctl_reg_sel = ctl_sel && (tgt == TGT_DATA);
    end

endmodule

// File: rtl/fdcio_motor_latch.sv
// Module: fdcio_motor_latch
// One-bit storage for the shared motor enable. It loads on a qualified
// write and clears on a synchronous active-low reset, which has priority.
module fdcio_motor_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);

    // Purpose: hold the motor enable, reset dominant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/fdcio_decoder.sv
// Module: fdcio_decoder
// Top level of the floppy controller port decoder. The decode outputs are
// combinational from the address and strobes. The motor output is
// registered. Assumes strobes are sampled in the clk domain.
module fdcio_decoder
    import fdcio_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int BIT_EXP   = BIT_EXP_DEF,
    parameter int BIT_GRP   = BIT_GRP_DEF,
    parameter int BIT_FN_HI = BIT_FN_HI_DEF,
    parameter int BIT_FN_LO = BIT_FN_LO_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_d0,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic              ctl_sel,
    output logic              ctl_reg_sel,
    output logic              ctl_rd,
    output logic              ctl_wr,
    output logic              motor_on
);

    fdcio_tgt_t tgt;
    logic       motor_we;
    logic       addr_unused;

    // Purpose: mark the undecoded address bits as intentionally ignored
    assign addr_unused = ^io_addr;

    fdcio_addr_match #(
        .ADDR_W    (ADDR_W),
        .BIT_EXP   (BIT_EXP),
        .BIT_GRP   (BIT_GRP),
        .BIT_FN_HI (BIT_FN_HI),
        .BIT_FN_LO (BIT_FN_LO)
    ) i_match (
        .addr (io_addr),
        .tgt  (tgt)
    );

    fdcio_strobe_gate i_gate (
        .tgt         (tgt),
        .rd          (io_rd),
        .wr          (io_wr),
        .ctl_sel     (ctl_sel),
        .ctl_reg_sel (ctl_reg_sel),
        .ctl_rd      (ctl_rd),
        .ctl_wr      (ctl_wr),
        .motor_we    (motor_we)
    );

    fdcio_motor_latch i_motor (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (motor_we),
        .d     (io_d0),
        .q     (motor_on)
    );

endmodule

// File: rtl/fdcio_decoder_chk.sv
// Module: fdcio_decoder_chk
// Property checker bound to fdcio_decoder. It observes the ports and the
// internal motor load enable.
module fdcio_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_d0,
    input logic        io_rd,
    input logic        io_wr,
    input logic        ctl_sel,
    input logic        ctl_reg_sel,
    input logic        ctl_rd,
    input logic        ctl_wr,
    input logic        motor_on,
    input logic        motor_we
);

    // R1
    sel_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sel |-> (!io_addr[10] && !io_addr[7] && io_addr[8]));

    // R3
    regsel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_sel |-> !ctl_reg_sel);

    // R5
    status_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_addr[0]) |-> !ctl_wr);

    // R8
    strobe_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_wr) |-> (!ctl_sel && !motor_we));

    // R6
    motor_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        motor_we |=> (motor_on == $past(io_d0)));

    // R7
    motor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !motor_we |=> $stable(motor_on));

    // R9
    motor_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !motor_on);

endmodule

bind fdcio_decoder fdcio_decoder_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_d0       (io_d0),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .ctl_sel     (ctl_sel),
    .ctl_reg_sel (ctl_reg_sel),
    .ctl_rd      (ctl_rd),
    .ctl_wr      (ctl_wr),
    .motor_on    (motor_on),
    .motor_we    (motor_we)
);

// File: tb/test_fdcio_decoder.sv
// Bench: sweeps the four decoded bits, many fills of the ignored bits and
// all strobe combinations. Expected values come from the requirements.
module test_fdcio_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'hFFFF;
    logic        io_d0 = 1'b0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        ctl_sel, ctl_reg_sel, ctl_rd, ctl_wr, motor_on;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic model_motor = 1'b0;

    fdcio_decoder i_fdcio_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_addr     (io_addr),
        .io_d0       (io_d0),
        .io_rd       (io_rd),
        .io_wr       (io_wr),
        .ctl_sel     (ctl_sel),
        .ctl_reg_sel (ctl_reg_sel),
        .ctl_rd      (ctl_rd),
        .ctl_wr      (ctl_wr),
        .motor_on    (motor_on)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Purpose: end a hung run as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input logic act,
                         input logic exp, input logic [15:0] a);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s addr=%h rd=%0b wr=%0b actual=%0b expected=%0b",
                     req, a, io_rd, io_wr, act, exp);
        end
    endtask

    initial begin
        logic e_rd, e_wr, e_sel, e_rs, e_mwe, hit;
        logic [15:0] fill, a;
        // R9: reset with a motor-on write pending
        io_addr = 16'hFA7E; io_d0 = 1'b1; io_wr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(motor_on == 1'b0, "R9 reset dominant", motor_on, 1'b0, io_addr);
        io_wr = 1'b0; io_d0 = 1'b0; io_addr = 16'hFFFF;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(motor_on == 1'b0, "R9 reset state", motor_on, 1'b0, io_addr);

        for (int f = 0; f < 20; f++) begin
            if (f < 16)       fill = ~(16'h1 << f);
            else if (f == 16) fill = 16'hFFFF;
            else if (f == 17) fill = 16'h0000;
            else if (f == 18) fill = 16'hAAAA;
            else              fill = 16'h5555;
            for (int c = 0; c < 16; c++) begin
                for (int s = 0; s < 4; s++) begin
                    @(negedge clk);
                    // R6 R7: motor result of the previous edge
                    check(motor_on == model_motor, "R6 R7 motor", motor_on,
                          model_motor, io_addr);
                    a = fill & ~16'h0581;
                    a[10] = c[3]; a[8] = c[2]; a[7] = c[1]; a[0] = c[0];
                    io_addr = a;
                    io_rd = s[0];
                    io_wr = s[1];
                    io_d0 = ~io_d0 ^ f[0];
                    #1;
                    hit   = !a[10] && !a[7];
                    e_rd  = hit && a[8] && io_rd && !io_wr;
                    e_wr  = hit && a[8] && a[0] && io_wr && !io_rd;
                    e_sel = e_rd || e_wr;
                    e_rs  = e_sel && a[0];
                    e_mwe = hit && !a[8] && !a[0] && io_wr && !io_rd;
                    // R1 R2: select over every fill of the ignored bits
                    check(ctl_sel == e_sel, "R1 R2 sel", ctl_sel, e_sel, a);
                    check(ctl_reg_sel == e_rs, "R3 reg_sel", ctl_reg_sel, e_rs, a);
                    check(ctl_rd == e_rd, "R4 rd", ctl_rd, e_rd, a);
                    check(ctl_wr == e_wr, "R5 wr", ctl_wr, e_wr, a);
                    if (io_rd && io_wr)
                        check(!ctl_sel && !ctl_rd && !ctl_wr, "R8 clash",
                              ctl_sel | ctl_rd | ctl_wr, 1'b0, a);
                    @(posedge clk);
                    if (e_mwe) model_motor = io_d0;
                end
            end
        end

        // R6: explicit on then off through the canonical motor address
        @(negedge clk); io_addr = 16'hFA7E; io_rd = 0; io_wr = 1; io_d0 = 1;
        @(negedge clk);
        check(motor_on == 1'b1, "R6 motor on", motor_on, 1'b1, io_addr);
        io_addr = 16'hFA7F; io_d0 = 0;  // R7: unassigned alias
        @(negedge clk);
        check(motor_on == 1'b1, "R7 alias ignored", motor_on, 1'b1, io_addr);
        io_addr = 16'hFA7E; io_d0 = 0;
        @(negedge clk);
        check(motor_on == 1'b0, "R6 motor off", motor_on, 1'b0, io_addr);
        io_wr = 0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule